// File: doc/BRIEF.md
# Multi-function GPIO pin controller

This block holds the control state for one general-purpose I/O pin. The same pin is shared with four other uses: a reset input, an analog channel, a serial acknowledge line and a pin-change interrupt input. The CPU writes four one-bit registers through a strobed register port: output data, direction, pull-up and open-drain. From these registers and from the function enables, the block produces the pad controls. These are the output enable, separate NMOS and PMOS driver enables, the pull-up enable and the enable of the digital input gate.

A fixed priority picks the pin's mode. Reset use comes first, then analog, then the secondary inputs (acknowledge-in and pin-change interrupt), then plain GPIO. Any mode other than GPIO turns the output driver off, whatever the direction register holds. The digital input gate opens only when something needs the pad value: always in reset and secondary modes, never in analog mode, and in GPIO mode only while the CPU read strobe is low. This keeps a floating pad from causing leakage through the input stage. While the gate is shut, every digital value taken from the pad reads as 0.

The pad value is passed to the reset filter, the acknowledge receiver and the interrupt controller. The CPU reads either the output data register or the gated pad value. The output driver can take its level from an external acknowledge-out source in place of the data register.

Top module: `mfpin_ctrl`

## Requirements
- R1: When `cfg_rst_en` is 1, the pin is in reset mode. In this mode `pad_pu_en` is 1 whatever the pull-up register holds, `pad_ie` is 1, both drivers are off, and `rst_lvl` equals `pad_in`. In every other mode `rst_lvl` is 0.
- R2: When `ana_sel` is 1 and `cfg_rst_en` is 0, the pin is in analog mode. In this mode `ana_en` is 1, `pad_ie` is 0, and `ack_in`, `pci_in` and `rst_lvl` are 0. `ana_en` is 0 in every other mode.
- R3: Outside reset mode, `pad_pu_en` equals the pull-up register, whatever the direction register holds.
- R4: In GPIO mode with direction 1 and open-drain 1, `pad_nmos_en` is 1 when the drive level is 0, both drivers are off when the drive level is 1, and `pad_pmos_en` is never 1.
- R5: In GPIO mode with direction 1 and open-drain 0, a drive level of 1 gives `pad_pmos_en`=1 and `pad_nmos_en`=0, and a drive level of 0 gives the reverse. `pad_oe` is 1 whenever either driver is on, and the two drivers are never on together.
- R6: If any of `cfg_rst_en`, `ana_sel`, `ack_in_en` or `pci_en` is 1, `pad_nmos_en`, `pad_pmos_en` and `pad_oe` are 0, even when the direction register is 1.
- R7: When `ack_in_en` or `pci_en` is 1 and neither reset nor analog mode is active, the pin is in secondary mode. In this mode `pad_ie` is 1 whatever `rd_n` is. `ack_in` equals `pad_in` when `ack_in_en` is 1 and is 0 otherwise; `pci_in` does the same with `pci_en`.
- R8: In GPIO mode (all four function enables 0), `pad_ie` equals the inverse of `rd_n`.
- R9: `rd_data` equals the data register when the direction register is 1. When direction is 0, it equals `pad_in` while `pad_ie` is 1 and reads 0 while `pad_ie` is 0.
- R10: All four registers are 0 after a cycle with `rst` high. A rising clock edge with `wr_en` and `port_sel` both 1 loads `wr_bit` into the register chosen by `wr_addr`: 0 is data, 1 is direction, 2 is pull-up, 3 is open-drain. No register changes unless both strobes are 1.
- R11: The drive level is `ack_out` when `ack_out_en` is 1, and the data register otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| port_sel | input | 1 | Port select for register writes |
| wr_addr | input | 2 | Register offset of the write |
| wr_bit | input | 1 | Value written |
| rd_n | input | 1 | CPU read strobe, active low |
| rd_data | output | 1 | CPU read value |
| cfg_rst_en | input | 1 | Configuration bit selecting reset use of the pin |
| ana_sel | input | 1 | Analog channel select |
| ack_in_en | input | 1 | Acknowledge-in function enable |
| pci_en | input | 1 | Pin-change interrupt input enable |
| ack_out_en | input | 1 | Take the drive level from ack_out |
| ack_out | input | 1 | Acknowledge-out level |
| pad_in | input | 1 | Level seen at the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_nmos_en | output | 1 | Pull-down driver enable |
| pad_pmos_en | output | 1 | Pull-up driver enable |
| pad_pu_en | output | 1 | Weak pull-up enable |
| pad_ie | output | 1 | Digital input gate enable |
| ana_en | output | 1 | Analog path enable |
| rst_lvl | output | 1 | Pad level to the reset filter |
| ack_in | output | 1 | Pad level to the acknowledge receiver |
| pci_in | output | 1 | Pad level to the interrupt controller |

## Verification
Apart from the four registers, the block is combinational. A wrong register bit therefore appears at the ports in the cycle after the write that set it. A bad direction or data bit shows at `rd_data` and at the driver enables. A bad pull-up or open-drain bit shows at `pad_pu_en` or at `pad_pmos_en`. A wrong mode decision shows at once, in the same cycle, as a driver left on, a gate left open in analog mode, or a secondary output that does not follow the pad. For these reasons the bench checks every output once per cycle against a model. The inputs are mostly random, and a few directed sequences cover the override corners.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;

    typedef enum logic [1:0] {
        PM_GPIO   = 2'd0,
        PM_SEC    = 2'd1,
        PM_ANALOG = 2'd2,
        PM_RESET  = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic dat;
        logic dir;
        logic pull;
        logic odrain;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic nmos_en;
        logic pmos_en;
        logic pull_en;
    } pad_drv_t;

    typedef struct packed {
        logic in_gate;
        logic ana_en;
        logic rst_lvl;
        logic ack_in;
        logic pci_in;
    } pad_rx_t;

    localparam int unsigned NUM_CFG_REGS = 4;

    // Fixed priority: reset use, then analog, then secondary inputs, then GPIO.
    function automatic pin_mode_e pick_mode(input logic rst_en, input logic ana,
                                            input logic sec);
        if (rst_en)   return PM_RESET;
        else if (ana) return PM_ANALOG;
        else if (sec) return PM_SEC;
        else          return PM_GPIO;
    endfunction

    // The input stage opens only when some consumer needs the pad level.
    function automatic logic gate_needed(input pin_mode_e mode, input logic rd_n);
        case (mode)
            PM_RESET:  return 1'b1;
            PM_SEC:    return 1'b1;
            PM_ANALOG: return 1'b0;
            default:   return ~rd_n;
        endcase
    endfunction

endpackage

// File: rtl/mfpin_cfg_regs.sv
module mfpin_cfg_regs
    import mfpin_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned OFS_DATA   = 0,
    parameter int unsigned OFS_DIR    = 1,
    parameter int unsigned OFS_PULL   = 2,
    parameter int unsigned OFS_ODRAIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output pin_cfg_t          cfg
);

    localparam int unsigned OFFS [NUM_CFG_REGS] = '{OFS_DATA, OFS_DIR, OFS_PULL, OFS_ODRAIN};

    logic                    hit;
    logic [NUM_CFG_REGS-1:0] bits_q;

    assign hit = wr_en & port_sel;

    for (genvar g = 0; g < NUM_CFG_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[g] <= 1'b0;
            end else if (hit && (wr_addr == ADDR_W'(OFFS[g]))) begin
                bits_q[g] <= wr_bit;
            end
        end
    end

    always_comb begin
        cfg.dat    = bits_q[0];
        cfg.dir    = bits_q[1];
        cfg.pull   = bits_q[2];
        cfg.odrain = bits_q[3];
    end

    AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_addr == ADDR_W'(OFS_DIR)) |=> (cfg.dir == $past(wr_bit))); // R10
    AST_NO_STROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cfg)); // R10

endmodule

// File: rtl/mfpin_mode_arb.sv
module mfpin_mode_arb
    import mfpin_pkg::*;
(
    input  logic      cfg_rst_en,
    input  logic      ana_sel,
    input  logic      ack_in_en,
    input  logic      pci_en,
    output pin_mode_e mode
);

    logic sec_any;

    assign sec_any = ack_in_en | pci_en;
    assign mode    = pick_mode(cfg_rst_en, ana_sel, sec_any);

endmodule

// File: rtl/mfpin_drive.sv
module mfpin_drive
    import mfpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  pin_cfg_t  cfg,
    input  logic      ack_out_en,
    input  logic      ack_out,
    output pad_drv_t  drv
);

    logic drive_ok;
    logic level;

    assign drive_ok = (mode == PM_GPIO) & cfg.dir;
    assign level    = ack_out_en ? ack_out : cfg.dat;

    always_comb begin
        drv.nmos_en = drive_ok & ~level;
        drv.pmos_en = drive_ok & level & ~cfg.odrain;
        drv.oe      = drv.nmos_en | drv.pmos_en;
        drv.pull_en = (mode == PM_RESET) | cfg.pull;
    end

    AST_NO_CROWBAR: assert property (@(posedge clk) disable iff (rst)
        !(drv.nmos_en && drv.pmos_en)); // R5
    AST_OD_NO_PMOS: assert property (@(posedge clk) disable iff (rst)
        cfg.odrain |-> !drv.pmos_en); // R4
    AST_OVERRIDE_DRIVER_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode != PM_GPIO) |-> (!drv.nmos_en && !drv.pmos_en && !drv.oe)); // R6
    AST_RST_PULLUP: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RESET) |-> drv.pull_en); // R1

endmodule

// File: rtl/mfpin_input.sv
module mfpin_input
    import mfpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  pin_cfg_t  cfg,
    input  logic      rd_n,
    input  logic      pad_in,
    input  logic      ack_in_en,
    input  logic      pci_en,
    output pad_rx_t   rx,
    output logic      rd_data
);

    logic gate;
    logic in_val;

    assign gate   = gate_needed(mode, rd_n);
    assign in_val = gate & pad_in;

    always_comb begin
        rx.in_gate = gate;
        rx.ana_en  = (mode == PM_ANALOG);
        rx.rst_lvl = (mode == PM_RESET) & in_val;
        rx.ack_in  = (mode == PM_SEC) & ack_in_en & in_val;
        rx.pci_in  = (mode == PM_SEC) & pci_en & in_val;
    end

    assign rd_data = cfg.dir ? cfg.dat : in_val;

    AST_ANALOG_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_ANALOG) |-> (!rx.in_gate && !rx.ack_in && !rx.pci_in)); // R2
    AST_SEC_GATE_ON: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SEC) |-> rx.in_gate); // R7
    AST_GPIO_GATE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_GPIO) |-> (rx.in_gate == !rd_n)); // R8
    AST_READ_OUT_REG: assert property (@(posedge clk) disable iff (rst)
        cfg.dir |-> (rd_data == cfg.dat)); // R9

endmodule

// File: rtl/mfpin_ctrl.sv
module mfpin_ctrl
    import mfpin_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned OFS_DATA   = 0,
    parameter int unsigned OFS_DIR    = 1,
    parameter int unsigned OFS_PULL   = 2,
    parameter int unsigned OFS_ODRAIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic              rd_n,
    output logic              rd_data,
    input  logic              cfg_rst_en,
    input  logic              ana_sel,
    input  logic              ack_in_en,
    input  logic              pci_en,
    input  logic              ack_out_en,
    input  logic              ack_out,
    input  logic              pad_in,
    output logic              pad_oe,
    output logic              pad_nmos_en,
    output logic              pad_pmos_en,
    output logic              pad_pu_en,
    output logic              pad_ie,
    output logic              ana_en,
    output logic              rst_lvl,
    output logic              ack_in,
    output logic              pci_in
);

    pin_cfg_t  cfg;
    pin_mode_e mode;
    pad_drv_t  drv;
    pad_rx_t   rx;

    mfpin_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .OFS_DATA  (OFS_DATA),
        .OFS_DIR   (OFS_DIR),
        .OFS_PULL  (OFS_PULL),
        .OFS_ODRAIN(OFS_ODRAIN)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .port_sel(port_sel),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .cfg     (cfg)
    );

    mfpin_mode_arb u_arb (
        .cfg_rst_en(cfg_rst_en),
        .ana_sel   (ana_sel),
        .ack_in_en (ack_in_en),
        .pci_en    (pci_en),
        .mode      (mode)
    );

    mfpin_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cfg       (cfg),
        .ack_out_en(ack_out_en),
        .ack_out   (ack_out),
        .drv       (drv)
    );

    mfpin_input u_input (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .cfg      (cfg),
        .rd_n     (rd_n),
        .pad_in   (pad_in),
        .ack_in_en(ack_in_en),
        .pci_en   (pci_en),
        .rx       (rx),
        .rd_data  (rd_data)
    );

    assign pad_oe      = drv.oe;
    assign pad_nmos_en = drv.nmos_en;
    assign pad_pmos_en = drv.pmos_en;
    assign pad_pu_en   = drv.pull_en;
    assign pad_ie      = rx.in_gate;
    assign ana_en      = rx.ana_en;
    assign rst_lvl     = rx.rst_lvl;
    assign ack_in      = rx.ack_in;
    assign pci_in      = rx.pci_in;

    AST_ANALOG_NO_SEC_OUT: assert property (@(posedge clk) disable iff (rst)
        (ana_sel && !cfg_rst_en) |-> (!rst_lvl && !ack_in && !pci_in && ana_en)); // R2
    AST_RST_WINS: assert property (@(posedge clk) disable iff (rst)
        cfg_rst_en |-> (pad_ie && !ana_en && !pad_oe)); // R1

endmodule

// File: tb/test_mfpin_ctrl.sv
module test_mfpin_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, port_sel, wr_bit, rd_n;
    logic [1:0] wr_addr;
    logic       cfg_rst_en, ana_sel, ack_in_en, pci_en, ack_out_en, ack_out, pad_in;
    logic       rd_data, pad_oe, pad_nmos_en, pad_pmos_en, pad_pu_en, pad_ie;
    logic       ana_en, rst_lvl, ack_in, pci_in;

    int checks = 0;
    int errors = 0;

    // bench copy of the registers, updated from R10
    logic m_dat = 1'b0, m_dir = 1'b0, m_pull = 1'b0, m_od = 1'b0;

    always #10 clk = ~clk;

    mfpin_ctrl i_mfpin_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .port_sel(port_sel), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .rd_n(rd_n), .rd_data(rd_data), .cfg_rst_en(cfg_rst_en),
        .ana_sel(ana_sel), .ack_in_en(ack_in_en), .pci_en(pci_en),
        .ack_out_en(ack_out_en), .ack_out(ack_out), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_nmos_en(pad_nmos_en), .pad_pmos_en(pad_pmos_en),
        .pad_pu_en(pad_pu_en), .pad_ie(pad_ie), .ana_en(ana_en), .rst_lvl(rst_lvl),
        .ack_in(ack_in), .pci_in(pci_in)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // mode number from R1, R2, R7, R8: 3 reset, 2 analog, 1 secondary, 0 gpio
    function automatic int exp_mode();
        if (cfg_rst_en) return 3;
        if (ana_sel) return 2;
        if (ack_in_en || pci_en) return 1;
        return 0;
    endfunction

    task automatic check_all();
        int   md;
        logic lvl, drv_ok, e_n, e_p, e_ie, e_in;
        md     = exp_mode();
        lvl    = ack_out_en ? ack_out : m_dat;                 // R11
        drv_ok = (md == 0) && m_dir;                           // R6
        e_n    = drv_ok && !lvl;                               // R4 R5
        e_p    = drv_ok && lvl && !m_od;                       // R4 R5
        e_ie   = (md == 3) ? 1'b1 : (md == 2) ? 1'b0 : (md == 1) ? 1'b1 : !rd_n;
        e_in   = e_ie & pad_in;
        chk("R4 R5 R6 R11", "pad_nmos_en", pad_nmos_en, e_n);
        chk("R4 R5 R6 R11", "pad_pmos_en", pad_pmos_en, e_p);
        chk("R5 R6", "pad_oe", pad_oe, e_n | e_p);
        chk("R1 R3", "pad_pu_en", pad_pu_en, (md == 3) || m_pull);
        chk("R1 R2 R7 R8", "pad_ie", pad_ie, e_ie);
        chk("R2", "ana_en", ana_en, md == 2);
        chk("R1", "rst_lvl", rst_lvl, (md == 3) && pad_in);
        chk("R7", "ack_in", ack_in, (md == 1) && ack_in_en && pad_in);
        chk("R7", "pci_in", pci_in, (md == 1) && pci_en && pad_in);
        chk("R9", "rd_data", rd_data, m_dir ? m_dat : e_in);
    endtask

    // inputs already set; check mid-cycle, then clock and update the model
    task automatic step();
        #2;
        check_all();
        @(posedge clk);
        #1;
        if (rst) begin
            m_dat = 0; m_dir = 0; m_pull = 0; m_od = 0;
        end else if (wr_en && port_sel) begin
            case (wr_addr)
                2'd0: m_dat  = wr_bit;
                2'd1: m_dir  = wr_bit;
                2'd2: m_pull = wr_bit;
                default: m_od = wr_bit;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 0; port_sel = 0; wr_addr = 0; wr_bit = 0; rd_n = 1;
        cfg_rst_en = 0; ana_sel = 0; ack_in_en = 0; pci_en = 0;
        ack_out_en = 0; ack_out = 0; pad_in = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic b);
        wr_en = 1; port_sel = 1; wr_addr = a; wr_bit = b;
        step();
        wr_en = 0; port_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        quiet();
        rst = 1;
        @(negedge clk);
        step();
        step();
        rst = 0;
        // R10 reset state: everything 0, pad read gated
        step();
        pad_in = 1; rd_n = 0; step();                 // R8 R9 gate opens on read
        rd_n = 1; step();                             // R9 gate shut reads 0
        // R10 write without port select has no effect
        wr_en = 1; port_sel = 0; wr_addr = 2'd1; wr_bit = 1; step();
        wr_en = 0; step();
        // R3 pull-up with direction 0 and 1
        wr(2'd2, 1); step();
        wr(2'd1, 1); wr(2'd0, 1); step();             // R5 push-pull high
        wr(2'd0, 0); step();                          // R5 push-pull low
        wr(2'd3, 1); step();                          // R4 open-drain low
        wr(2'd0, 1); step();                          // R4 open-drain floats
        ack_out_en = 1; ack_out = 0; step();          // R11 ack level drives
        ack_out_en = 0;
        pci_en = 1; pad_in = 1; step();               // R6 R7
        pci_en = 0; ana_sel = 1; step();              // R2 R6
        cfg_rst_en = 1; step();                       // R1 reset wins
        wr(2'd2, 0); step();                          // R1 pull forced
        quiet();
        // random section
        for (int i = 0; i < 4000; i++) begin
            wr_en      = $urandom_range(0, 2) == 0;
            port_sel   = $urandom_range(0, 3) != 0;
            wr_addr    = 2'($urandom_range(0, 3));
            wr_bit     = 1'($urandom_range(0, 1));
            rd_n       = 1'($urandom_range(0, 1));
            cfg_rst_en = $urandom_range(0, 7) == 0;
            ana_sel    = $urandom_range(0, 5) == 0;
            ack_in_en  = $urandom_range(0, 4) == 0;
            pci_en     = $urandom_range(0, 4) == 0;
            ack_out_en = $urandom_range(0, 3) == 0;
            ack_out    = 1'($urandom_range(0, 1));
            pad_in     = 1'($urandom_range(0, 1));
            rst        = (i == 2000);
            step();
        end
        rst = 0;
        quiet();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule